// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the instruction that configures vector length in a scalar core with a vector extension. Each accepted instruction word names a destination register index, a source register index, a 7-bit immediate and two selector flags. From these it works out a new maximum length and a new active length. The new active length never exceeds the new maximum. The surrounding pipeline supplies the source register value, the current active and maximum lengths, and the summary-overflow bit.

One cycle after a valid word, the block pulses a single strobe that updates both length registers together. If the destination index is nonzero, it also writes the final active length to that general-purpose register. If the record bit is set, it writes condition field 0 from that same length. A word with the wrong opcode, the wrong extended opcode or a set reserved bit causes no writes and raises an illegal pulse instead. With both register indices zero, the instruction acts as a pure "set maximum" or "set length from immediate" operation, with no register-file side effects.

Top module: `vlen_set_unit`

## Requirements
- R1: A word is legal only when bits 0..5 (bit 0 is the MSB) equal 19, bits 26..30 equal the extended code parameter (default 27) and bit 23 is zero. For any other word, `illegal` pulses and `len_we`, `gpr_we` and `cond_we` stay low.
- R2: When the length-select flag (bit 24) is set and the source index (bits 11..15) is nonzero, the candidate length is `src_val`, taken as an unsigned 64-bit number. Values above the maximum clamp to the maximum.
- R3: When the length-select flag is set and the source index is zero, the candidate length is the immediate in bits 16..22.
- R4: When the length-select flag is clear, the candidate length is `cur_len`.
- R5: When the max-select flag (bit 25) is set, the new maximum is the immediate; otherwise it is `cur_max`. The final length is the unsigned minimum of the candidate and the new maximum. `len_next` and `max_next` are presented together under one `len_we` pulse.
- R6: When the destination index (bits 6..10) is nonzero, `gpr_we` pulses with `gpr_idx` equal to that index and `gpr_data` equal to the final length, zero-extended. When the index is zero, `gpr_we` stays low.
- R7: When the record bit (bit 31) is set, `cond_we` pulses with `cond_val` = {neg, pos, zero, ovf}, MSB first. Here neg=0, pos=(final length>0), zero=(final length==0), and ovf is `so_in` sampled with the word. When the record bit is clear, `cond_we` stays low.
- R8: All outputs appear in the cycle after the one in which `in_valid` is sampled high. When `in_valid` was low, every strobe and `illegal` is low.
- R9: While `rst` is high, and in the first cycle after it, every strobe and `illegal` is low, even when `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word, bit 0 = MSB |
| src_val | input | XLEN | Value read from the source register |
| cur_len | input | LEN_W | Current active length register |
| cur_max | input | LEN_W | Current maximum length register |
| so_in | input | 1 | Current summary-overflow bit |
| len_we | output | 1 | Update strobe for both length registers |
| len_next | output | LEN_W | New active length |
| max_next | output | LEN_W | New maximum length |
| gpr_we | output | 1 | Register file write strobe |
| gpr_idx | output | 5 | Register file write index |
| gpr_data | output | XLEN | Register file write data |
| cond_we | output | 1 | Condition field 0 write strobe |
| cond_val | output | 4 | Condition field value {neg,pos,zero,ovf} |
| illegal | output | 1 | Word did not decode as this instruction |

## Verification
All state lives in a single rank of output registers. A wrong source choice, a wrong clamp or a stale selector therefore shows up exactly one cycle after the offending word, as a wrong `len_next`, `max_next`, `gpr_data` or condition bit. A strobe stuck high shows up in the idle cycle that follows. The sweep covers every immediate value under all four selector combinations, with source values below, at and far above the maximum. This means an off-by-one in the comparison, a signed comparison or a truncated compare shows up on some immediate boundary.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

    localparam int IDX_W = 5;
    localparam int IMM_W = 7;
    localparam int CR_W  = 4;
    localparam logic [5:0] PRIMARY_OPC = 6'd19;

    // Field layout, MSB first (bit 0 of the word is the MSB).
    typedef struct packed {
        logic [5:0]       opc;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] src;
        logic [IMM_W-1:0] imm;
        logic             rsvd;
        logic             len_sel;
        logic             max_sel;
        logic [4:0]       xop;
        logic             rec;
    } op_word_t;

    typedef enum logic [1:0] {
        LSRC_KEEP = 2'd0,
        LSRC_IMM  = 2'd1,
        LSRC_REG  = 2'd2
    } len_src_e;

    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic ovf;
    } cond_t;

    function automatic len_src_e pick_src(input logic len_sel, input logic [IDX_W-1:0] src);
        if (!len_sel)        return LSRC_KEEP;
        else if (src != '0)  return LSRC_REG;
        else                 return LSRC_IMM;
    endfunction

    function automatic cond_t cond_of(input logic is_zero, input logic ovf);
        cond_t c;
        c.neg  = 1'b0;
        c.pos  = !is_zero;
        c.zero = is_zero;
        c.ovf  = ovf;
        return c;
    endfunction

endpackage

// File: rtl/vlen_decode.sv
module vlen_decode import vlen_pkg::*; #(
    parameter logic [4:0] XOP = 5'd27
) (
    input  logic [31:0]      instr,
    output logic             legal,
    output len_src_e         src_kind,
    output logic             max_sel,
    output logic [IMM_W-1:0] imm,
    output logic [IDX_W-1:0] dst,
    output logic             rec
);
    op_word_t w;

    assign w        = op_word_t'(instr);
    assign legal    = (w.opc == PRIMARY_OPC) && (w.xop == XOP) && !w.rsvd;
    assign src_kind = pick_src(w.len_sel, w.src);
    assign max_sel  = w.max_sel;
    assign imm      = w.imm;
    assign dst      = w.dst;
    assign rec      = w.rec;

    always_comb begin
        assert (!(w.len_sel == 1'b0) || src_kind == LSRC_KEEP)
            else $error("p_keep_src_r4: cleared select must keep current length");
    end
endmodule

// File: rtl/vlen_resolve.sv
module vlen_resolve import vlen_pkg::*; #(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  len_src_e         src_kind,
    input  logic             max_sel,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  src_val,
    input  logic [LEN_W-1:0] cur_len,
    input  logic [LEN_W-1:0] cur_max,
    output logic [LEN_W-1:0] new_len,
    output logic [LEN_W-1:0] new_max,
    output logic             len_zero
);
    logic [LEN_W-1:0] imm_ext;
    logic [XLEN-1:0]  cand;
    logic [XLEN-1:0]  max_wide;

    generate
        if (LEN_W == IMM_W) begin : g_imm_same
            assign imm_ext = imm;
        end else if (LEN_W > IMM_W) begin : g_imm_pad
            assign imm_ext = {{(LEN_W-IMM_W){1'b0}}, imm};
        end else begin : g_imm_cut
            assign imm_ext = imm[LEN_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (src_kind)
            LSRC_REG: cand = src_val;
            LSRC_IMM: cand = XLEN'(imm_ext);
            default:  cand = XLEN'(cur_len);
        endcase
    end

    assign new_max  = max_sel ? imm_ext : cur_max;
    assign max_wide = XLEN'(new_max);
    assign new_len  = (cand < max_wide) ? LEN_W'(cand) : new_max;
    assign len_zero = (new_len == '0);

    always_comb begin
        assert (new_len <= new_max)
            else $error("p_min_comb_r5: final length above maximum");
    end
endmodule

// File: rtl/vlen_commit.sv
module vlen_commit import vlen_pkg::*; #(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             legal,
    input  logic [LEN_W-1:0] new_len,
    input  logic [LEN_W-1:0] new_max,
    input  logic             len_zero,
    input  logic [IDX_W-1:0] dst,
    input  logic             rec,
    input  logic             so_in,
    output logic             len_we,
    output logic [LEN_W-1:0] len_next,
    output logic [LEN_W-1:0] max_next,
    output logic             gpr_we,
    output logic [IDX_W-1:0] gpr_idx,
    output logic [XLEN-1:0]  gpr_data,
    output logic             cond_we,
    output logic [CR_W-1:0]  cond_val,
    output logic             illegal
);
    logic  take;
    cond_t cond_d;

    assign take   = in_valid && legal;
    assign cond_d = cond_of(len_zero, so_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_we   <= 1'b0;
            gpr_we   <= 1'b0;
            cond_we  <= 1'b0;
            illegal  <= 1'b0;
            len_next <= '0;
            max_next <= '0;
            gpr_idx  <= '0;
            cond_val <= '0;
        end else begin
            len_we  <= take;
            gpr_we  <= take && (dst != '0);
            cond_we <= take && rec;
            illegal <= in_valid && !legal;
            if (take) begin
                len_next <= new_len;
                max_next <= new_max;
                gpr_idx  <= dst;
                cond_val <= cond_d;
            end
        end
    end

    assign gpr_data = XLEN'(len_next);

    p_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        len_we |-> (len_next <= max_next));

    p_illegal_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(len_we || gpr_we || cond_we));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(len_we || gpr_we || cond_we || illegal));

    p_dst_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (gpr_idx != '0) && len_we);

    p_cond_code_r7: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> !cond_val[3] && ($countones(cond_val[2:1]) == 1)
                    && (cond_val[1] == (len_next == '0)) && len_we);

    p_cond_ovf_r7: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> (cond_val[0] == $past(so_in)));
endmodule

// File: rtl/vlen_set_unit.sv
module vlen_set_unit import vlen_pkg::*; #(
    parameter int         XLEN  = 64,
    parameter int         LEN_W = 7,
    parameter logic [4:0] XOP   = 5'd27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [XLEN-1:0]   src_val,
    input  logic [LEN_W-1:0]  cur_len,
    input  logic [LEN_W-1:0]  cur_max,
    input  logic              so_in,
    output logic              len_we,
    output logic [LEN_W-1:0]  len_next,
    output logic [LEN_W-1:0]  max_next,
    output logic              gpr_we,
    output logic [4:0]        gpr_idx,
    output logic [XLEN-1:0]   gpr_data,
    output logic              cond_we,
    output logic [3:0]        cond_val,
    output logic              illegal
);
    logic             legal;
    len_src_e         src_kind;
    logic             max_sel;
    logic [IMM_W-1:0] imm;
    logic [IDX_W-1:0] dst;
    logic             rec;
    logic [LEN_W-1:0] new_len;
    logic [LEN_W-1:0] new_max;
    logic             len_zero;

    vlen_decode #(.XOP(XOP)) u_decode (
        .instr    (instr),
        .legal    (legal),
        .src_kind (src_kind),
        .max_sel  (max_sel),
        .imm      (imm),
        .dst      (dst),
        .rec      (rec)
    );

    vlen_resolve #(.XLEN(XLEN), .LEN_W(LEN_W)) u_resolve (
        .src_kind (src_kind),
        .max_sel  (max_sel),
        .imm      (imm),
        .src_val  (src_val),
        .cur_len  (cur_len),
        .cur_max  (cur_max),
        .new_len  (new_len),
        .new_max  (new_max),
        .len_zero (len_zero)
    );

    vlen_commit #(.XLEN(XLEN), .LEN_W(LEN_W)) u_commit (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .legal    (legal),
        .new_len  (new_len),
        .new_max  (new_max),
        .len_zero (len_zero),
        .dst      (dst),
        .rec      (rec),
        .so_in    (so_in),
        .len_we   (len_we),
        .len_next (len_next),
        .max_next (max_next),
        .gpr_we   (gpr_we),
        .gpr_idx  (gpr_idx),
        .gpr_data (gpr_data),
        .cond_we  (cond_we),
        .cond_val (cond_val),
        .illegal  (illegal)
    );
endmodule

// File: tb/vlen_set_unit_tb.sv
`timescale 1ns/1ps
module vlen_set_unit_tb;
    localparam int XLEN  = 64;
    localparam int LEN_W = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [31:0]       instr = '0;
    logic [XLEN-1:0]   src_val = '0;
    logic [LEN_W-1:0]  cur_len = '0;
    logic [LEN_W-1:0]  cur_max = '0;
    logic              so_in = 1'b0;
    logic              len_we;
    logic [LEN_W-1:0]  len_next;
    logic [LEN_W-1:0]  max_next;
    logic              gpr_we;
    logic [4:0]        gpr_idx;
    logic [XLEN-1:0]   gpr_data;
    logic              cond_we;
    logic [3:0]        cond_val;
    logic              illegal;

    int ntests = 0;
    int nfail  = 0;

    always #2 clk = ~clk;

    vlen_set_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .cur_len(cur_len), .cur_max(cur_max), .so_in(so_in),
        .len_we(len_we), .len_next(len_next), .max_next(max_next),
        .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
        .cond_we(cond_we), .cond_val(cond_val), .illegal(illegal)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] xop,
                                       input logic [4:0] dst, input logic [4:0] src,
                                       input logic [6:0] imm, input logic rsv,
                                       input logic ls, input logic ms, input logic rec);
        return {opc, dst, src, imm, rsv, ls, ms, xop, rec};
    endfunction

    task automatic strobes_low(input string tag);
        chk(!len_we,  tag, 64'(len_we), 0);
        chk(!gpr_we,  tag, 64'(gpr_we), 0);
        chk(!cond_we, tag, 64'(cond_we), 0);
        chk(!illegal, tag, 64'(illegal), 0);
    endtask

    // One legal word: drive, check next cycle, check idle cycle.
    task automatic run_legal(input logic [4:0] dst, input logic [4:0] src, input logic [6:0] imm,
                             input logic ls, input logic ms, input logic rec,
                             input logic [63:0] sv, input logic [6:0] cl, input logic [6:0] cm,
                             input logic so);
        logic [63:0] cand, mx, fin;
        logic [3:0]  ecv;
        string       tag;
        if (ls && src != 0)      begin cand = sv;           tag = "R2"; end
        else if (ls)             begin cand = 64'(imm);     tag = "R3"; end
        else                     begin cand = 64'(cl);      tag = "R4"; end
        mx  = ms ? 64'(imm) : 64'(cm);
        fin = (cand < mx) ? cand : mx;
        ecv = {1'b0, fin != 0, fin == 0, so};
        @(negedge clk);
        instr = mk(6'd19, 5'd27, dst, src, imm, 1'b0, ls, ms, rec);
        src_val = sv; cur_len = cl; cur_max = cm; so_in = so; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(len_we == 1'b1, "R8 len_we", 64'(len_we), 1);
        chk(illegal == 1'b0, "R1 legal", 64'(illegal), 0);
        chk(64'(len_next) == fin, {tag, "/R5 len"}, 64'(len_next), fin);
        chk(64'(max_next) == mx, "R5 max", 64'(max_next), mx);
        chk(gpr_we == (dst != 0), "R6 gpr_we", 64'(gpr_we), 64'(dst != 0));
        if (dst != 0) begin
            chk(gpr_idx == dst, "R6 idx", 64'(gpr_idx), 64'(dst));
            chk(gpr_data == fin, "R6 data", gpr_data, fin);
        end
        chk(cond_we == rec, "R7 cond_we", 64'(cond_we), 64'(rec));
        if (rec) chk(cond_val == ecv, "R7 cond", 64'(cond_val), 64'(ecv));
        @(negedge clk);
        strobes_low("R8 idle");
    endtask

    task automatic run_bad(input logic [31:0] w, input string tag);
        @(negedge clk);
        instr = w; in_valid = 1'b1; src_val = 64'd9; cur_len = 7'd3; cur_max = 7'd9;
        @(negedge clk);
        in_valid = 1'b0;
        chk(illegal == 1'b1, {tag, " illegal"}, 64'(illegal), 1);
        chk(!(len_we || gpr_we || cond_we), {tag, " writes"}, 64'({len_we, gpr_we, cond_we}), 0);
        @(negedge clk);
        strobes_low("R8 idle after bad");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        ntests++; nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        logic [63:0] svals [4];
        logic [6:0]  cls [3];
        logic [6:0]  cms [3];
        svals[0] = 64'd0; svals[1] = 64'd5; svals[2] = 64'd200; svals[3] = '1;
        cls[0] = 7'd3;   cms[0] = 7'd10;
        cls[1] = 7'd100; cms[1] = 7'd20;
        cls[2] = 7'd127; cms[2] = 7'd127;

        // R9: reset holds strobes low even with a valid legal word
        instr = mk(6'd19, 5'd27, 5'd4, 5'd0, 7'd8, 1'b0, 1'b1, 1'b1, 1'b1);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        strobes_low("R9 in reset");
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        strobes_low("R9 after reset");

        // pure set-maximum and set-length forms with no register side effects
        run_legal(5'd0, 5'd0, 7'd8, 1'b0, 1'b1, 1'b0, 64'd0, 7'd50, 7'd90, 1'b0);
        run_legal(5'd0, 5'd0, 7'd8, 1'b1, 1'b0, 1'b0, 64'd0, 7'd50, 7'd90, 1'b0);
        // R2 huge value clamps under unsigned compare
        run_legal(5'd4, 5'd3, 7'd64, 1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 7'd1, 7'd1, 1'b1);

        for (int i = 0; i < 128; i++)
            for (int f = 0; f < 4; f++)
                for (int s = 0; s < 2; s++)
                    for (int v = 0; v < 4; v++)
                        for (int c = 0; c < 3; c++)
                            run_legal(((i + v) % 3 == 0) ? 5'd0 : 5'(1 + ((i + c) % 31)),
                                      (s == 0) ? 5'd0 : 5'(1 + v),
                                      7'(i), f[0], f[1], 1'((i + c) & 1),
                                      svals[v], cls[c], cms[c], 1'(f ^ v));

        // R1 illegal encodings
        run_bad(mk(6'd18, 5'd27, 5'd4, 5'd0, 7'd8, 1'b0, 1'b1, 1'b1, 1'b1), "R1 opc18");
        run_bad(mk(6'd31, 5'd27, 5'd4, 5'd0, 7'd8, 1'b0, 1'b1, 1'b1, 1'b1), "R1 opc31");
        run_bad(mk(6'd19, 5'd26, 5'd4, 5'd0, 7'd8, 1'b0, 1'b1, 1'b1, 1'b1), "R1 xop26");
        run_bad(mk(6'd19, 5'd0,  5'd4, 5'd0, 7'd8, 1'b0, 1'b1, 1'b1, 1'b1), "R1 xop0");
        run_bad(mk(6'd19, 5'd27, 5'd4, 5'd0, 7'd8, 1'b1, 1'b1, 1'b1, 1'b1), "R1 rsvd");

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule